// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block is a serial slave that gives a microcontroller read and write access to a bank of eight 8-bit control registers. The host uses three signals: an active-high select, a shift clock and a single data line that both ends share. Each transaction is a 12-bit frame. The frame carries a direction bit, a 3-bit register address sent MSB first, and eight data bits sent MSB first. On a read, the block takes the data line over once the address is complete and shifts the register contents back to the host.

All three serial inputs are sampled by the fast system clock through synchronizers. Because of this, the shift clock must stay low and high for at least five system clocks in each half period. For pad-level flexibility the shared data line is split into an input, an output and an output enable; the tristate buffer sits in the pad ring. The whole bank is presented as one flat parallel bus, so the logic it controls can use the bits directly. Address 7 returns a live status byte supplied from outside and cannot be written. Address 5 has no storage and always reads zero. An active-low power-down input clears the bank to its reset values.

Top module: `ctl_port`

## Requirements
- R1: After `rst` is high for one clock edge, `regs_o` equals 64'h0000_0000_0033_0000 (slot 2 holds 8'h33, every other slot is 0) and `cfg_sdo_oe` is 0.
- R2: A write frame writes its data byte into the register at its address; the register changes only after the 12th bit.
  - The host drives each bit on `cfg_sdi`, and the block samples it on a rising edge of `cfg_sck` while `cfg_en` is 1.
  - Bit order: bit 0 is the direction (0 = write), bits 1 to 3 are the address MSB first, and bits 4 to 11 are the data MSB first.
- R3: A read frame (direction bit 1) makes the block drive the data line during the data phase.
  - `cfg_sdo_oe` stays 0 during the four header bits.
  - From the falling edge that follows the 4th rising edge, `cfg_sdo_oe` is 1 and `cfg_sdo` carries the addressed register MSB first, with one new bit after each falling edge.
- R4: Address 7 reads back the current value of `status_in`, and a write frame to address 7 changes no register.
- R5: Address 5 always reads 8'h00, and its `regs_o` slot stays 0 even after a write frame to it.
- R6: A frame that ends (`cfg_en` back to 0) before its 12th rising edge changes no register.
- R7: `cfg_sdo_oe` returns to 0 within five clocks of `cfg_en` going to 0, and also after the falling edge that follows the 12th bit of a read.
- R8: Holding `pdn_n` low clears every register to its R1 reset value. Writing any value to address 0, including one with bit 5 set, resets nothing.
- R9: Rising edges beyond the 12th within one frame are ignored: the frame performs exactly one write, using bits 4 to 11.
- R10: Slot i of `regs_o` (bits 8i+7 down to 8i) always shows the content of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| pdn_n | input | 1 | Active-low power-down; clears the register bank |
| cfg_en | input | 1 | Active-high frame select from the host |
| cfg_sck | input | 1 | Serial shift clock from the host |
| cfg_sdi | input | 1 | Data line as seen at the pad input |
| cfg_sdo | output | 1 | Data driven toward the pad during reads |
| cfg_sdo_oe | output | 1 | Pad output enable for the data line |
| status_in | input | 8 | Live status byte returned at address 7 |
| regs_o | output | 64 | Flat view of the eight registers, slot i at bits 8i+7:8i |

## Verification
The bench aims at the turnaround point of a read. A design that enabled its driver one bit early would contend with the host during the last address bit, and one that loaded the data one edge late would return every byte shifted by one bit. It also covers frames that end early and frames that run past twelve bits. A design that committed on every rising edge, or that failed to stop at the twelfth bit, would leave a partial or shifted byte in the register. Further tests write to the status address and to the empty address, which a naive bank would store and return. Finally, a power-down pulse is applied after the reset value at address 2 has been overwritten, which would expose a clear path that zeroes that register instead of restoring 8'h33.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int CTL_DW = 8;
  typedef logic [CTL_DW-1:0] ctl_byte_t;

  localparam int        CTL_GAIN_ADDR = 2;
  localparam ctl_byte_t CTL_GAIN_INIT = 8'h33;

  function automatic ctl_byte_t ctl_reset_value(input int idx);
    return (idx == CTL_GAIN_ADDR) ? CTL_GAIN_INIT : '0;
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ctl_frame.sv
module ctl_frame
  import ctl_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  ctl_byte_t     rd_data,
  output logic [AW-1:0] addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output ctl_byte_t     wr_data,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int DW    = CTL_DW;
  localparam int FRAME = 1 + AW + DW;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME - 1);
  localparam logic [CW-1:0] HDR_BITS = CW'(AW + 1);
  localparam logic [CW-1:0] FULL     = CW'(FRAME);

  logic            sck_d;
  logic            rise, fall;
  logic [CW-1:0]   bitcnt;
  logic [FRAME-2:0] sh;
  logic            dir;
  ctl_byte_t       tx;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign rise = sck_s & ~sck_d;
  assign fall = ~sck_s & sck_d;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst || !en_s) begin
      bitcnt <= '0;
      dir    <= 1'b0;
      sdo_oe <= 1'b0;
      sh     <= '0;
      tx     <= '0;
      addr   <= '0;
      if (rst) begin
        wr_addr <= '0;
        wr_data <= '0;
      end
    end else begin
      if (rise && bitcnt < FULL) begin
        sh     <= {sh[FRAME-3:0], sdi_s};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CW'(AW)) begin
          dir  <= sh[AW-1];
          addr <= {sh[AW-2:0], sdi_s};
        end
        if (bitcnt == LAST_BIT && !dir) begin
          wr_en   <= 1'b1;
          wr_addr <= addr;
          wr_data <= {sh[DW-2:0], sdi_s};
        end
      end
      if (fall && dir && bitcnt >= HDR_BITS) begin
        if (bitcnt == HDR_BITS) begin
          tx     <= rd_data;
          sdo_oe <= 1'b1;
        end else if (bitcnt < FULL) begin
          tx <= {tx[DW-2:0], 1'b0};
        end else begin
          sdo_oe <= 1'b0;
        end
      end
    end
  end

  assign sdo = tx[DW-1];

  AST_OE_DROPS_WITHOUT_EN: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> !sdo_oe); // R7

  AST_OE_STARTS_AFTER_HEADER: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> (dir && bitcnt == HDR_BITS)); // R3

  AST_SINGLE_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R9

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !sdo_oe); // R2
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
  import ctl_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int RO_ADDR  = 7,
  parameter int NUL_ADDR = 5,
  localparam int AW = $clog2(NREG),
  localparam int DW = CTL_DW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  ctl_byte_t          wr_data,
  input  logic [AW-1:0]      rd_addr,
  input  ctl_byte_t          status,
  output ctl_byte_t          rd_data,
  output logic [NREG*DW-1:0] regs_flat
);
  ctl_byte_t slot [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == RO_ADDR || i == NUL_ADDR) begin : g_none
        assign slot[i] = '0;
      end else begin : g_store
        always_ff @(posedge clk) begin
          if (rst || clr)
            slot[i] <= ctl_reset_value(i);
          else if (wr_en && wr_addr == AW'(i))
            slot[i] <= wr_data;
        end

        AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
          (!clr && !(wr_en && wr_addr == AW'(i))) |=> $stable(slot[i])); // R6

        AST_CLEAR_TO_INIT: assert property (@(posedge clk) disable iff (rst)
          clr |=> slot[i] == ctl_reset_value(i)); // R8
      end
      assign regs_flat[i*DW +: DW] = slot[i];
    end
  endgenerate

  assign rd_data = (rd_addr == AW'(RO_ADDR)) ? status : slot[rd_addr];
endmodule

// File: rtl/ctl_port.sv
module ctl_port
  import ctl_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int RO_ADDR     = 7,
  parameter int NUL_ADDR    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pdn_n,
  input  logic                   cfg_en,
  input  logic                   cfg_sck,
  input  logic                   cfg_sdi,
  output logic                   cfg_sdo,
  output logic                   cfg_sdo_oe,
  input  logic [CTL_DW-1:0]      status_in,
  output logic [NREG*CTL_DW-1:0] regs_o
);
  localparam int AW = $clog2(NREG);

  logic [3:0]    pins_s;
  logic          pdn_s, en_s, sck_s, sdi_s;
  logic [AW-1:0] addr, wr_addr;
  logic          wr_en;
  ctl_byte_t     wr_data, rd_data;

  ctl_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pdn_n, cfg_en, cfg_sck, cfg_sdi}),
    .q   (pins_s)
  );
  assign {pdn_s, en_s, sck_s, sdi_s} = pins_s;

  ctl_frame #(.AW(AW)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .en_s    (en_s),
    .sck_s   (sck_s),
    .sdi_s   (sdi_s),
    .rd_data (rd_data),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sdo     (cfg_sdo),
    .sdo_oe  (cfg_sdo_oe)
  );

  ctl_bank #(.NREG(NREG), .RO_ADDR(RO_ADDR), .NUL_ADDR(NUL_ADDR)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .clr       (~pdn_s),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (addr),
    .status    (status_in),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );
endmodule

// File: tb/ctl_port_bench.sv
module ctl_port_bench;
  localparam int HALF = 10;
  localparam logic [63:0] INIT = 64'h0000_0000_0033_0000;
  // {read, addr[2:0], data[7:0], expected[7:0]}
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'hA5, 8'hA5},
    {1'b0, 3'd1, 8'h3C, 8'h3C},
    {1'b0, 3'd2, 8'hFF, 8'hFF},
    {1'b0, 3'd3, 8'h81, 8'h81},
    {1'b0, 3'd4, 8'h7E, 8'h7E},
    {1'b0, 3'd6, 8'hC3, 8'hC3},
    {1'b0, 3'd5, 8'hFF, 8'h00},
    {1'b1, 3'd0, 8'h00, 8'hA5},
    {1'b1, 3'd2, 8'h00, 8'hFF},
    {1'b1, 3'd5, 8'h00, 8'h00},
    {1'b1, 3'd6, 8'h00, 8'hC3}
  };

  logic clk = 0, rst = 1, pdn_n = 1, cfg_en = 0, cfg_sck = 0, cfg_sdi = 0;
  logic cfg_sdo, cfg_sdo_oe;
  logic [7:0]  status_in = 8'h96;
  logic [63:0] regs_o;
  int checks = 0, failures = 0;
  bit done = 0;

  ctl_port u_ctl_port (
    .clk(clk), .rst(rst), .pdn_n(pdn_n), .cfg_en(cfg_en), .cfg_sck(cfg_sck),
    .cfg_sdi(cfg_sdi), .cfg_sdo(cfg_sdo), .cfg_sdo_oe(cfg_sdo_oe),
    .status_in(status_in), .regs_o(regs_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit rd, input logic [2:0] a, input logic [7:0] d,
                       input int nbits, output logic [7:0] got, output bit oe_bad);
    got = '0; oe_bad = 0;
    @(negedge clk); cfg_en = 1; clks(4);
    for (int i = 0; i < nbits; i++) begin
      cfg_sck = 0;
      if (i == 0) cfg_sdi = rd;
      else if (i < 4) cfg_sdi = a[3-i];
      else if (i < 12) cfg_sdi = rd ? 1'b0 : d[11-i];
      else cfg_sdi = 1'b1;
      clks(HALF);
      if (i < 4 && cfg_sdo_oe) oe_bad = 1;
      if (rd && i >= 4 && i < 12) begin
        if (!cfg_sdo_oe) oe_bad = 1;
        got[11-i] = cfg_sdo;
      end
      cfg_sck = 1; clks(HALF);
    end
    cfg_sck = 0; clks(HALF);
    if (nbits >= 12 && rd && cfg_sdo_oe) oe_bad = 1;
    cfg_en = 0; clks(6);
  endtask

  initial begin
    logic [7:0] got;
    bit bad;
    clks(3); rst = 0; clks(4);
    chk("R1 reset regs", regs_o, INIT);
    chk("R1 reset oe", {63'd0, cfg_sdo_oe}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      frame(VEC[v][19], VEC[v][18:16], VEC[v][15:8], 12, got, bad);
      if (VEC[v][19]) begin
        chk("R3 read data", {56'd0, got}, {56'd0, VEC[v][7:0]});
        chk("R3 oe window", {63'd0, bad}, 64'd0);
      end else begin
        chk("R2 R10 write slot", {56'd0, regs_o[VEC[v][18:16]*8 +: 8]}, {56'd0, VEC[v][7:0]});
      end
    end
    chk("R5 slot5 zero after write", {56'd0, regs_o[47:40]}, 64'd0);

    frame(1, 3'd7, 8'h00, 12, got, bad);
    chk("R4 status read", {56'd0, got}, 64'h96);
    status_in = 8'h4B;
    frame(0, 3'd7, 8'hFF, 12, got, bad);
    chk("R4 write to status ignored", regs_o, 64'h00C3_007E_81FF_3CA5);
    frame(1, 3'd7, 8'h00, 12, got, bad);
    chk("R4 status follows input", {56'd0, got}, 64'h4B);

    frame(0, 3'd1, 8'h00, 9, got, bad);
    chk("R6 aborted write", {56'd0, regs_o[15:8]}, 64'h3C);
    frame(0, 3'd1, 8'h00, 11, got, bad);
    chk("R6 abort at 11 bits", {56'd0, regs_o[15:8]}, 64'h3C);

    @(negedge clk); cfg_en = 1; clks(4);
    for (int i = 0; i < 7; i++) begin
      cfg_sck = 0; cfg_sdi = (i == 0) ? 1'b1 : 1'b0; clks(HALF);
      cfg_sck = 1; clks(HALF);
    end
    cfg_sck = 0; clks(HALF);
    chk("R7 oe on mid-read", {63'd0, cfg_sdo_oe}, 64'd1);
    cfg_en = 0; clks(5);
    chk("R7 oe off after en low", {63'd0, cfg_sdo_oe}, 64'd0);
    frame(1, 3'd3, 8'h00, 12, got, bad);
    chk("R7 oe released after read", {63'd0, bad}, 64'd0);

    frame(0, 3'd3, 8'h18, 16, got, bad);
    chk("R9 long frame", {56'd0, regs_o[31:24]}, 64'h18);

    frame(0, 3'd0, 8'h20, 12, got, bad);
    chk("R8 bit5 write no reset", regs_o, 64'h00C3_007E_18FF_3C20);
    @(negedge clk); pdn_n = 0; clks(4); pdn_n = 1; clks(4);
    chk("R8 pdn clears", regs_o, INIT);

    frame(0, 3'd4, 8'h11, 12, got, bad);
    @(negedge clk); rst = 1; clks(1); rst = 0; clks(1);
    chk("R1 rst clears", regs_o, INIT);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule